// File: doc/BRIEF.md
# Receive Character Queue with Accumulated Error Status

This block sits between a serial receiver's deserialiser and the host. The receiver pushes each completed character, together with three per-character condition flags: break seen, parity mismatch and framing fault. The host pops characters in arrival order. The queue holds 16 characters. The head entry, meaning the next character the host will read, is always presented on the read side together with its own flags.

The block also keeps a sticky four-bit error status word. It collects the break, parity and framing flags of the characters it has handled, plus an overrun bit that is set when the receiver pushes into a full queue. The status word does not describe a single character. It records that some character since the last clear had a problem. By default, a character's flags enter the status only when that character becomes the head. A select pulse switches the block to a second policy, in which flags also enter the status the moment a character is pushed. This gives the earliest warning, but the host can no longer tell which character caused it. That second policy stays in force until a device reset or a receiver reset. A clear input wipes all four status bits together. A receiver-reset input empties the queue and restores the default policy.

Top module: `rx_err_fifo`

## Requirements
- R1: The queue holds 16 characters. `level_o` counts the stored entries, `fifo_full_o` is high at 16 and `fifo_empty_o` is high at 0. Characters and their flags come out of `head_*` in the order they were pushed.
- R2: Status bit positions are [3] break, [2] framing, [1] parity and [0] overrun. Flag inputs map to status bits of the same name. After reset, the status is 0 and the queue is empty.
- R3: A push while the queue is full, with no pop accepted in the same cycle, is dropped. Contents and level do not change, and the overrun bit is set from the next cycle.
- R4: A pop while the queue is empty has no effect on level, head or status.
- R5: Default policy: a character's flags enter the status one cycle after it becomes the head. A character pushed into an empty queue becomes head in the same cycle it is written.
- R6: Push policy: a pushed character's flags enter the status one cycle after the push, even when older characters are ahead of it.
- R7: A pulse on `push_acc_sel_i` selects the push policy from the next cycle. The push policy persists until `rst_n` or `rx_reset_i`, and further pulses change nothing.
- R8: `clr_err_i` clears all four status bits from the next cycle.
- R9: Flags merged in the same cycle as a clear survive that clear.
- R10: `rx_reset_i` empties the queue and restores the default policy. Any push or pop in that cycle is ignored, and the status word is left unchanged.
- R11: A push and a pop in the same cycle are both accepted when the queue is not empty, including when it is full. In that case the level is unchanged and no overrun is raised.
- R12: Status bits are sticky. Once set, a bit stays set until a clear or `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| push_i | input | 1 | Receiver offers a character |
| push_data_i | input | 8 | Character value |
| push_brk_i | input | 1 | Break flag of the pushed character |
| push_frm_i | input | 1 | Framing fault flag of the pushed character |
| push_par_i | input | 1 | Parity mismatch flag of the pushed character |
| pop_i | input | 1 | Host consumes the head character |
| clr_err_i | input | 1 | Clear accumulated error status |
| push_acc_sel_i | input | 1 | Select push-time accumulation |
| rx_reset_i | input | 1 | Receiver reset: flush queue, default policy |
| head_data_o | output | 8 | Head character value |
| head_brk_o | output | 1 | Head break flag |
| head_frm_o | output | 1 | Head framing flag |
| head_par_o | output | 1 | Head parity flag |
| fifo_empty_o | output | 1 | Queue empty |
| fifo_full_o | output | 1 | Queue full |
| level_o | output | 5 | Number of stored characters |
| err_status_o | output | 4 | Accumulated status {break, framing, parity, overrun} |

## Verification
The storage assertions assume that the top never writes into a full queue without a simultaneous read, and never reads an empty one. The gating at the top guarantees this, so the stimulus may offer pushes when the queue is full and pops when it is empty, and the bench does so on purpose. The accumulator assertions assume that every merge request arrives in the same cycle as the push or head change that causes it. Inputs change only at falling edges and are held for one whole cycle, so each push, pop, clear or select is a single-cycle event. The bench deliberately combines events (clear with merge, push with pop, receiver reset with push) to reach the priority cases.

// File: rtl/rxq_pkg.sv
// Package: shared widths, status bit positions and entry types for the
// receive character queue. Assumes 8-bit characters.
package rxq_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 3;
    localparam int STAT_W = 4;

    // Status bit positions (order visible to the host)
    localparam int ST_OVR = 0;
    localparam int ST_PAR = 1;
    localparam int ST_FRM = 2;
    localparam int ST_BRK = 3;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_flags_t;

    typedef struct packed {
        rxq_flags_t         flags;
        logic [DATA_W-1:0]  data;
    } rxq_entry_t;

    typedef enum logic {
        ACC_AT_HEAD = 1'b0,
        ACC_AT_PUSH = 1'b1
    } rxq_acc_mode_e;
endpackage

// File: rtl/rxq_store.sv
// Module: circular storage for character entries with read/write pointers
// and an occupancy counter. Presents the head entry and the entry behind it.
// Assumes the caller never writes when full without a same-cycle read and
// never reads when empty; flush has priority over both.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic                     wr_i,
    input  rxq_entry_t               wr_entry_i,
    input  logic                     rd_i,
    output rxq_entry_t               head_o,
    output rxq_entry_t               next_o,
    output logic [$clog2(DEPTH):0]   count_o,
    output logic                     empty_o,
    output logic                     full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rxq_entry_t        mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    // Write the incoming entry into the slot under the write pointer
    always_ff @(posedge clk) begin
        if (wr_i && !flush_i) begin
            mem[wr_ptr] <= wr_entry_i;
        end
    end

    // Advance pointers and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (wr_i) wr_ptr <= ptr_inc(wr_ptr);
            if (rd_i) rd_ptr <= ptr_inc(rd_ptr);
            case ({wr_i, rd_i})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Expose head, the entry behind it and occupancy flags
    always_comb begin
        head_o  = mem[rd_ptr];
        next_o  = mem[ptr_inc(rd_ptr)];
        count_o = count_q;
        empty_o = (count_q == '0);
        full_o  = (count_q == CW'(DEPTH));
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !flush_i) |-> (!full_o || rd_i));
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !flush_i) |-> !empty_o);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (empty_o && count_o == '0));
endmodule

// File: rtl/rxq_merge_sel.sv
// Module: decides which character flags join the error status this cycle.
// Head policy: flags of whichever character becomes the head. Push policy:
// also the flags of the character being pushed. Assumes push_ok/pop_ok are
// already gated against full, empty and receiver reset.
module rxq_merge_sel
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  rxq_acc_mode_e            mode_i,
    input  logic                     push_ok_i,
    input  logic                     pop_ok_i,
    input  logic [$clog2(DEPTH):0]   count_i,
    input  rxq_flags_t               push_flags_i,
    input  rxq_flags_t               next_flags_i,
    output rxq_flags_t               merge_o
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic       head_from_next;
    logic       head_from_push;
    rxq_flags_t at_head;
    rxq_flags_t at_push;

    // Work out which character, if any, becomes the new head
    always_comb begin
        head_from_next = pop_ok_i && (count_i > CW'(1));
        head_from_push = push_ok_i &&
                         ((count_i == '0) || (pop_ok_i && count_i == CW'(1)));
    end

    // Select and combine the flag sources
    always_comb begin
        if (head_from_next)      at_head = next_flags_i;
        else if (head_from_push) at_head = push_flags_i;
        else                     at_head = '0;
        at_push = (mode_i == ACC_AT_PUSH && push_ok_i) ? push_flags_i : '0;
        merge_o = at_head | at_push;
    end
endmodule

// File: rtl/rxq_err_accum.sv
// Module: sticky four-bit error status. A clear wipes the held bits; merges
// and overrun in the same cycle are ORed in after the clear.
module rxq_err_accum
    import rxq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  rxq_flags_t         merge_i,
    input  logic               ovr_i,
    output logic [STAT_W-1:0]  status_o
);
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] incoming;

    // Map character flags and overrun onto status positions
    always_comb begin
        incoming         = '0;
        incoming[ST_BRK] = merge_i.brk;
        incoming[ST_FRM] = merge_i.frm;
        incoming[ST_PAR] = merge_i.par;
        incoming[ST_OVR] = ovr_i;
    end

    // Hold status; clear first, then add new bits
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (clr_i ? '0 : status_q) | incoming;
    end

    assign status_o = status_q;

    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && merge_i == '0 && !ovr_i) |=> (status_o == '0));
    assert_merge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && merge_i.par) |=> status_o[ST_PAR]);
endmodule

// File: rtl/rx_err_fifo.sv
// Module: receive character queue with accumulated error status.
// Gates push/pop against full, empty and receiver reset, holds the
// accumulation policy and ties storage, merge selection and status together.
// Assumes all control inputs are synchronous to clk.
module rx_err_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic [7:0]               push_data_i,
    input  logic                     push_brk_i,
    input  logic                     push_frm_i,
    input  logic                     push_par_i,
    input  logic                     pop_i,
    input  logic                     clr_err_i,
    input  logic                     push_acc_sel_i,
    input  logic                     rx_reset_i,
    output logic [7:0]               head_data_o,
    output logic                     head_brk_o,
    output logic                     head_frm_o,
    output logic                     head_par_o,
    output logic                     fifo_empty_o,
    output logic                     fifo_full_o,
    output logic [$clog2(DEPTH):0]   level_o,
    output logic [3:0]               err_status_o
);
    localparam int CW = $clog2(DEPTH) + 1;

    rxq_acc_mode_e   mode_q;
    rxq_entry_t      wr_entry;
    rxq_entry_t      head;
    rxq_entry_t      next;
    rxq_flags_t      merge;
    logic [CW-1:0]   count;
    logic            empty;
    logic            full;
    logic            pop_ok;
    logic            push_ok;
    logic            overrun;

    // Accept or drop requests
    always_comb begin
        pop_ok         = pop_i && !empty && !rx_reset_i;
        push_ok        = push_i && !rx_reset_i && (!full || pop_ok);
        overrun        = push_i && !rx_reset_i && full && !pop_ok;
        wr_entry.data  = push_data_i;
        wr_entry.flags = '{brk: push_brk_i, frm: push_frm_i, par: push_par_i};
    end

    // Accumulation policy register
    always_ff @(posedge clk) begin
        if (!rst_n || rx_reset_i) mode_q <= ACC_AT_HEAD;
        else if (push_acc_sel_i)  mode_q <= ACC_AT_PUSH;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (rx_reset_i),
        .wr_i       (push_ok),
        .wr_entry_i (wr_entry),
        .rd_i       (pop_ok),
        .head_o     (head),
        .next_o     (next),
        .count_o    (count),
        .empty_o    (empty),
        .full_o     (full)
    );

    rxq_merge_sel #(.DEPTH(DEPTH)) u_sel (
        .mode_i       (mode_q),
        .push_ok_i    (push_ok),
        .pop_ok_i     (pop_ok),
        .count_i      (count),
        .push_flags_i (wr_entry.flags),
        .next_flags_i (next.flags),
        .merge_o      (merge)
    );

    rxq_err_accum u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_err_i),
        .merge_i  (merge),
        .ovr_i    (overrun),
        .status_o (err_status_o)
    );

    // Drive read-side outputs
    always_comb begin
        head_data_o  = head.data;
        head_brk_o   = head.flags.brk;
        head_frm_o   = head.flags.frm;
        head_par_o   = head.flags.par;
        fifo_empty_o = empty;
        fifo_full_o  = full;
        level_o      = count;
    end

    assert_overrun_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && fifo_full_o && !pop_i && !rx_reset_i) |=> err_status_o[ST_OVR]);
    assert_push_mode_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ACC_AT_PUSH && !rx_reset_i) |=> (mode_q == ACC_AT_PUSH));
    assert_empty_push_merges_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && push_par_i && fifo_empty_o && !rx_reset_i) |=> err_status_o[ST_PAR]);
    assert_rx_reset_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset_i |=> (level_o == '0 && mode_q == ACC_AT_HEAD));
endmodule

// File: tb/sim_rx_err_fifo.sv
module sim_rx_err_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       push_brk_i = 1'b0, push_frm_i = 1'b0, push_par_i = 1'b0;
    logic       pop_i = 1'b0, clr_err_i = 1'b0, push_acc_sel_i = 1'b0, rx_reset_i = 1'b0;
    logic [7:0] head_data_o;
    logic       head_brk_o, head_frm_o, head_par_o;
    logic       fifo_empty_o, fifo_full_o;
    logic [4:0] level_o;
    logic [3:0] err_status_o;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_err_fifo u0 (.*);

    // {push, data, flags(brk,frm,par), pop, clr, sel, rxr, level, status}
    localparam logic [24:0] VEC [16] = '{
        {1'b1, 8'hA5, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 4'b0000},
        {1'b1, 8'h3C, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2, 4'b0000},
        {1'b1, 8'h0F, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 4'b0000},
        {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd2, 4'b0010},
        {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 4'b0110},
        {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 4'b0000},
        {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 4'b0000},
        {1'b1, 8'h77, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 4'b1000},
        {1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 4'b0000},
        {1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 4'b0000},
        {1'b1, 8'h11, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 4'b0000},
        {1'b1, 8'h22, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2, 4'b0010},
        {1'b1, 8'h33, 3'b010, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3, 4'b0100},
        {1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 4'b0100},
        {1'b1, 8'h55, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 4'b0100},
        {1'b1, 8'h66, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2, 4'b0100}
    };
    string TAGS [16] = '{"R1", "R5", "R5", "R5", "R5", "R8", "R12", "R5",
                         "R8", "R7", "R6", "R6", "R9", "R10", "R10", "R7"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        push_i = 0; pop_i = 0; clr_err_i = 0; push_acc_sel_i = 0; rx_reset_i = 0;
        push_brk_i = 0; push_frm_i = 0; push_par_i = 0; push_data_i = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic push_one(input logic [7:0] d, input logic [2:0] f);
        push_i = 1; push_data_i = d;
        {push_brk_i, push_frm_i, push_par_i} = f;
        step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        chk("R2 reset level", 32'(level_o), 0);
        chk("R2 reset empty", 32'(fifo_empty_o), 1);
        chk("R2 reset status", 32'(err_status_o), 0);

        // Vector table
        for (int i = 0; i < 16; i++) begin
            logic [24:0] v;
            v = VEC[i];
            push_i = v[24]; push_data_i = v[23:16];
            {push_brk_i, push_frm_i, push_par_i} = v[15:13];
            pop_i = v[12]; clr_err_i = v[11]; push_acc_sel_i = v[10]; rx_reset_i = v[9];
            step();
            chk({TAGS[i], " level"}, 32'(level_o), 32'(v[8:4]));
            chk({TAGS[i], " status"}, 32'(err_status_o), 32'(v[3:0]));
        end

        // Order check on table leftovers: head is 55 then 66 with parity flag
        chk("R1 head data", 32'(head_data_o), 32'h55);
        pop_i = 1; step();
        chk("R1 head data next", 32'(head_data_o), 32'h66);
        chk("R1 head flag", 32'(head_par_o), 1);

        // Fill to full
        rx_reset_i = 1; clr_err_i = 1; step();
        for (int i = 0; i < 16; i++) push_one(8'h80 + 8'(i), 3'b000);
        chk("R1 full level", 32'(level_o), 16);
        chk("R1 full flag", 32'(fifo_full_o), 1);
        push_one(8'hEE, 3'b001);
        chk("R3 drop level", 32'(level_o), 16);
        chk("R3 overrun bit", 32'(err_status_o), 32'b0001);
        chk("R3 head kept", 32'(head_data_o), 32'h80);
        clr_err_i = 1; step();
        chk("R8 clear ovr", 32'(err_status_o), 0);

        // Push and pop together while full
        push_i = 1; push_data_i = 8'hCC; pop_i = 1; step();
        chk("R11 level", 32'(level_o), 16);
        chk("R11 no ovr", 32'(err_status_o), 0);
        chk("R11 head", 32'(head_data_o), 32'h81);
        for (int i = 0; i < 15; i++) begin
            chk("R1 order", 32'(head_data_o), 32'(8'h81 + 8'(i)));
            pop_i = 1; step();
        end
        chk("R1 last head", 32'(head_data_o), 32'hCC);
        pop_i = 1; step();
        chk("R1 drained", 32'(fifo_empty_o), 1);
        pop_i = 1; step();
        chk("R4 empty pop level", 32'(level_o), 0);
        chk("R4 empty pop status", 32'(err_status_o), 0);

        // Push policy persists through a second select, then device reset reverts it
        push_acc_sel_i = 1; step();
        push_acc_sel_i = 1; step();
        push_one(8'h01, 3'b000);
        push_one(8'h02, 3'b010);
        chk("R6 push merge", 32'(err_status_o), 32'b0100);
        rst_n = 0; step(); rst_n = 1;
        chk("R2 reset status", 32'(err_status_o), 0);
        push_one(8'h03, 3'b000);
        push_one(8'h04, 3'b100);
        chk("R7 default after reset", 32'(err_status_o), 0);

        // Receiver reset ignores a same-cycle push
        rx_reset_i = 1; push_i = 1; push_data_i = 8'h99; step();
        chk("R10 push ignored", 32'(level_o), 0);
        chk("R10 status kept", 32'(err_status_o), 0);

        done = 1;
        summary();
    end
endmodule